// File: doc/BRIEF.md
# Paged Memory Readout Sequencer with Page CRC

This block is the byte-level command engine on the device side of a serial memory bus. After a bus reset it waits for one command byte and then a two-byte start address, low byte first. It then answers each byte-read request with one byte. The memory is a synchronous read port with one cycle of latency, and so is the per-page write-cycle counter.

There are two read modes. In the linear mode, bytes come out from the start address up to the top of memory, and all-ones bytes follow after that. In the trailer mode, each 32-byte page ends with a 10-byte trailer:

- the page's write-cycle counter, 4 bytes, least significant byte first;
- a fixed tamper pattern, 4 bytes;
- the inverted CRC-16, low byte first.

The trailer is followed by the start of the next page. The first page's CRC also covers the command byte and both address bytes. Each later page's CRC starts again from zero.

The controller has eight named states:

- `ST_CMD`: waits for the command byte.
- `ST_ALO`: takes the low address byte.
- `ST_AHI`: takes the high address byte.
- `ST_DATA`: streams memory bytes.
- `ST_CNT`: sends the counter bytes.
- `ST_TAMP`: sends the tamper bytes.
- `ST_CRC`: sends the CRC bytes.
- `ST_ONES`: answers every read with all ones.

The transitions are as follows:

- `ST_CMD` moves to `ST_ALO` on a known command, or to `ST_ONES` on an unknown one.
- `ST_ALO` moves to `ST_AHI`, and `ST_AHI` moves to `ST_DATA`, each on a written byte.
- In linear mode, `ST_DATA` moves to `ST_ONES` after the last memory byte.
- In trailer mode, `ST_DATA` moves to `ST_CNT` after the last byte of a page.
- `ST_CNT` moves to `ST_TAMP`, and `ST_TAMP` moves to `ST_CRC`, each after four bytes.
- `ST_CRC` moves to `ST_DATA` after two bytes, or to `ST_ONES` if it has just finished the last page.
- `ST_DATA` also moves to `ST_ONES` when the start address lies outside memory.
- A bus reset moves any state back to `ST_CMD`.

Top module: `paged_read_seq`

## Requirements
- R1: Command byte 0xF0 selects linear mode. Each read returns the memory byte at the current address, starting at the target address, and the address then steps by one.
- R2: In linear mode, after the byte at the last memory address (0x1FF by default), every read returns 0xFF. A target address at or above the memory size returns 0xFF from the first read.
- R3: The first address byte written sets target bits 7:0 and the second sets bits 15:8. `target_addr` shows the received address and changes only when an address byte is taken.
- R4: Command byte 0xA5 selects trailer mode. Data runs to the end of the 32-byte page. Then come 4 counter bytes, 4 tamper bytes of 0x55 each, and 2 CRC bytes. The next read returns the first byte of the following page.
- R5: Counter bytes are sent least significant byte first. Pages below CNT_FIRST_PAGE (default 8) have no counter and report 0xFF in all four counter bytes.
- R6: The CRC uses polynomial x^16+x^15+x^2+1, is fed least significant bit first and starts at 0. For the first page it covers the command byte, the low address byte, the high address byte, the data bytes sent, the counter bytes and the tamper bytes. It is sent inverted, low byte first.
- R7: For every later page, the CRC starts again at 0 and covers only that page's data, counter and tamper bytes.
- R8: After the CRC of the last page, every read returns 0xFF until a bus reset. In trailer mode, a target address outside memory also returns 0xFF.
- R9: A bus reset in any state aborts the sequence. The engine then waits for a new command, and the CRC is cleared.
- R10: Any command byte other than 0xF0 or 0xA5 makes every read return 0xFF until a bus reset. Further written bytes have no effect, and `target_addr` keeps its value.
- R11: `rd_valid` is high for exactly one cycle, the cycle after each read request that is not in a bus-reset cycle. A read before the address is complete returns 0xFF. A byte written after the address phase has no effect on the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst | input | 1 | Bus reset pulse: abort and wait for a command |
| wr_valid | input | 1 | Byte written by the bus master |
| wr_data | input | 8 | Written byte |
| rd_req | input | 1 | Byte read request |
| rd_valid | output | 1 | Read byte valid, one cycle after `rd_req` |
| rd_data | output | 8 | Read byte |
| mem_en | output | 1 | Memory read enable |
| mem_addr | output | 9 | Memory byte address |
| mem_rdata | input | 8 | Memory data, one cycle after `mem_en` |
| cnt_en | output | 1 | Write-cycle counter read enable |
| cnt_page | output | 4 | Page whose counter is read |
| cnt_rdata | input | 32 | Counter value, one cycle after `cnt_en` |
| target_addr | output | 16 | Target address as received |

## Verification
The bench builds the block with its default parameters: 16 pages of 32 bytes, with counters from page 8 upward. With these values a page without a counter (0xFF counter bytes) and a page with one can both be reached in a single sweep, for example page 7 into page 8. The bench also reaches the final page, so the switch to all ones after the last CRC is covered, and it checks an address above the 512-byte memory. The bench computes every expected byte, including the chained CRC, from its own model of the stream.

// File: rtl/pgrd_pkg.sv
package pgrd_pkg;

    localparam logic [7:0] CMD_LINEAR  = 8'hF0;
    localparam logic [7:0] CMD_TRAILER = 8'hA5;

    typedef enum logic [2:0] {
        ST_CMD,
        ST_ALO,
        ST_AHI,
        ST_DATA,
        ST_CNT,
        ST_TAMP,
        ST_CRC,
        ST_ONES
    } seq_state_e;

    typedef enum logic [2:0] {
        K_ONES,
        K_DATA,
        K_CNT,
        K_TAMP,
        K_CRC
    } byte_kind_e;

endpackage

// File: rtl/pgrd_crc16.sv
module pgrd_crc16 #(
    parameter logic [15:0] POLY_REFL = 16'hA001
) (
    input  logic [15:0] crc_in,
    input  logic [7:0]  din,
    output logic [15:0] crc_out
);
    always_comb begin
        logic [15:0] c;
        c = crc_in;
        for (int i = 0; i < 8; i++) begin
            if (c[0] ^ din[i]) begin
                c = (c >> 1) ^ POLY_REFL;
            end else begin
                c = c >> 1;
            end
        end
        crc_out = c;
    end
endmodule

// File: rtl/pgrd_ctrl.sv
module pgrd_ctrl
    import pgrd_pkg::*;
#(
    parameter int PAGE_BYTES     = 32,
    parameter int PAGES          = 16,
    parameter int CNT_FIRST_PAGE = 8,
    localparam int PG_AW  = $clog2(PAGE_BYTES),
    localparam int MEM_AW = $clog2(PAGE_BYTES * PAGES),
    localparam int PAGE_W = $clog2(PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rst,
    input  logic              wr_valid,
    input  logic [7:0]        wr_data,
    input  logic              rd_req,
    output logic              req_acc,
    output byte_kind_e        req_kind,
    output logic [1:0]        req_idx,
    output logic              req_cnt,
    output logic              hdr_fold,
    output logic              mem_en,
    output logic [MEM_AW-1:0] mem_addr,
    output logic              cnt_en,
    output logic [PAGE_W-1:0] cnt_page,
    output logic [15:0]       target_addr
);
    localparam logic [PAGE_W-1:0] CNT_FIRST_P = PAGE_W'(CNT_FIRST_PAGE);
    localparam logic [PAGE_W-1:0] LAST_PAGE_P = PAGE_W'(PAGES - 1);
    localparam logic [15:0]       MEM_LAST    = 16'(PAGE_BYTES * PAGES - 1);

    seq_state_e  state_q, state_d;
    logic        linear_q, linear_d;
    logic [15:0] addr_q, addr_d;
    logic [15:0] tgt_q, tgt_d;
    logic [1:0]  idx_q, idx_d;

    logic              in_mem;
    logic              page_end;
    logic [PAGE_W-1:0] page;
    logic              has_cnt;

    assign in_mem   = (addr_q[15:MEM_AW] == '0);
    assign page     = addr_q[MEM_AW-1:PG_AW];
    assign page_end = (addr_q[PG_AW-1:0] == '1);
    assign has_cnt  = (page >= CNT_FIRST_P);
    assign req_acc  = rd_req & ~bus_rst;

    // Transition logic
    always_comb begin
        state_d  = state_q;
        linear_d = linear_q;
        addr_d   = addr_q;
        tgt_d    = tgt_q;
        idx_d    = idx_q;
        if (bus_rst) begin
            state_d = ST_CMD;
            idx_d   = '0;
        end else begin
            unique case (state_q)
                ST_CMD: if (wr_valid) begin
                    if (wr_data == CMD_LINEAR) begin
                        state_d  = ST_ALO;
                        linear_d = 1'b1;
                    end else if (wr_data == CMD_TRAILER) begin
                        state_d  = ST_ALO;
                        linear_d = 1'b0;
                    end else begin
                        state_d = ST_ONES;
                    end
                end
                ST_ALO: if (wr_valid) begin
                    addr_d[7:0] = wr_data;
                    tgt_d[7:0]  = wr_data;
                    state_d     = ST_AHI;
                end
                ST_AHI: if (wr_valid) begin
                    addr_d[15:8] = wr_data;
                    tgt_d[15:8]  = wr_data;
                    state_d      = ST_DATA;
                end
                ST_DATA: if (req_acc) begin
                    if (!in_mem) begin
                        state_d = ST_ONES;
                    end else if (linear_q) begin
                        if (addr_q == MEM_LAST) begin
                            state_d = ST_ONES;
                        end else begin
                            addr_d = addr_q + 16'd1;
                        end
                    end else if (page_end) begin
                        state_d = ST_CNT;
                        idx_d   = '0;
                    end else begin
                        addr_d = addr_q + 16'd1;
                    end
                end
                ST_CNT: if (req_acc) begin
                    idx_d = idx_q + 2'd1;
                    if (idx_q == 2'd3) begin
                        state_d = ST_TAMP;
                    end
                end
                ST_TAMP: if (req_acc) begin
                    idx_d = idx_q + 2'd1;
                    if (idx_q == 2'd3) begin
                        state_d = ST_CRC;
                    end
                end
                ST_CRC: if (req_acc) begin
                    if (idx_q == 2'd1) begin
                        idx_d = '0;
                        if (page == LAST_PAGE_P) begin
                            state_d = ST_ONES;
                        end else begin
                            addr_d  = addr_q + 16'd1;
                            state_d = ST_DATA;
                        end
                    end else begin
                        idx_d = idx_q + 2'd1;
                    end
                end
                ST_ONES: state_d = ST_ONES;
                default: state_d = ST_ONES;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_CMD;
            linear_q <= 1'b1;
            addr_q   <= '0;
            tgt_q    <= '0;
            idx_q    <= '0;
        end else begin
            state_q  <= state_d;
            linear_q <= linear_d;
            addr_q   <= addr_d;
            tgt_q    <= tgt_d;
            idx_q    <= idx_d;
        end
    end

    // Outputs
    always_comb begin
        req_kind = K_ONES;
        mem_en   = 1'b0;
        cnt_en   = 1'b0;
        hdr_fold = 1'b0;
        unique case (state_q)
            ST_CMD, ST_ALO, ST_AHI: hdr_fold = wr_valid & ~bus_rst;
            ST_DATA: begin
                req_kind = in_mem ? K_DATA : K_ONES;
                mem_en   = req_acc & in_mem;
            end
            ST_CNT: begin
                req_kind = K_CNT;
                cnt_en   = req_acc & has_cnt;
            end
            ST_TAMP: req_kind = K_TAMP;
            ST_CRC:  req_kind = K_CRC;
            ST_ONES: req_kind = K_ONES;
            default: req_kind = K_ONES;
        endcase
    end

    assign req_idx     = idx_q;
    assign req_cnt     = has_cnt;
    assign mem_addr    = addr_q[MEM_AW-1:0];
    assign cnt_page    = page;
    assign target_addr = tgt_q;

    p_addr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && linear_q && (addr_q != MEM_LAST)) |=> (addr_q == $past(addr_q) + 16'd1));

    p_trailer_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TAMP && req_acc && idx_q == 2'd3) |=> (state_q == ST_CRC));

    p_cnt_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_en |-> (cnt_page >= CNT_FIRST_P));

    p_ones_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ONES && !bus_rst) |=> (state_q == ST_ONES));

    p_reset_to_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> (state_q == ST_CMD));

    p_tgt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_ALO && state_q != ST_AHI) |=> $stable(tgt_q));
endmodule

// File: rtl/pgrd_outstage.sv
module pgrd_outstage
    import pgrd_pkg::*;
#(
    parameter logic [31:0] TAMPER = 32'h5555_5555
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_rst,
    input  logic        req_acc,
    input  byte_kind_e  req_kind,
    input  logic [1:0]  req_idx,
    input  logic        req_cnt,
    input  logic        hdr_fold,
    input  logic [7:0]  wr_data,
    input  logic [7:0]  mem_rdata,
    input  logic [31:0] cnt_rdata,
    output logic        rd_valid,
    output logic [7:0]  rd_data
);
    logic        out_valid_q;
    byte_kind_e  out_kind_q;
    logic [1:0]  out_idx_q;
    logic        out_cnt_q;
    logic [15:0] crc_q;
    logic [15:0] crc_next;
    logic [7:0]  fold_byte;
    logic        fold_out;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid_q <= 1'b0;
            out_kind_q  <= K_ONES;
            out_idx_q   <= '0;
            out_cnt_q   <= 1'b0;
        end else begin
            out_valid_q <= req_acc;
            if (req_acc) begin
                out_kind_q <= req_kind;
                out_idx_q  <= req_idx;
                out_cnt_q  <= req_cnt;
            end
        end
    end

    always_comb begin
        unique case (out_kind_q)
            K_DATA:  rd_data = mem_rdata;
            K_CNT:   rd_data = out_cnt_q ? cnt_rdata[8*out_idx_q +: 8] : 8'hFF;
            K_TAMP:  rd_data = TAMPER[8*out_idx_q +: 8];
            K_CRC:   rd_data = out_idx_q[0] ? ~crc_q[15:8] : ~crc_q[7:0];
            default: rd_data = 8'hFF;
        endcase
    end

    assign rd_valid  = out_valid_q;
    assign fold_out  = out_valid_q &&
                       (out_kind_q == K_DATA || out_kind_q == K_CNT || out_kind_q == K_TAMP);
    assign fold_byte = hdr_fold ? wr_data : rd_data;

    pgrd_crc16 #(.POLY_REFL(16'hA001)) u_crc (
        .crc_in  (crc_q),
        .din     (fold_byte),
        .crc_out (crc_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= '0;
        end else if (bus_rst) begin
            crc_q <= '0;
        end else if (hdr_fold || fold_out) begin
            crc_q <= crc_next;
        end else if (out_valid_q && out_kind_q == K_CRC && out_idx_q[0]) begin
            crc_q <= '0;
        end
    end

    p_crc_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_q && out_kind_q == K_CRC && !out_idx_q[0] && !bus_rst && !hdr_fold)
        |=> $stable(crc_q));

    p_crc_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_q && out_kind_q == K_CRC && out_idx_q[0]) |=> (crc_q == 16'h0000 || hdr_fold));
endmodule

// File: rtl/paged_read_seq.sv
module paged_read_seq
    import pgrd_pkg::*;
#(
    parameter int          PAGE_BYTES     = 32,
    parameter int          PAGES          = 16,
    parameter int          CNT_FIRST_PAGE = 8,
    parameter logic [31:0] TAMPER         = 32'h5555_5555,
    localparam int MEM_AW = $clog2(PAGE_BYTES * PAGES),
    localparam int PAGE_W = $clog2(PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rst,
    input  logic              wr_valid,
    input  logic [7:0]        wr_data,
    input  logic              rd_req,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              mem_en,
    output logic [MEM_AW-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    output logic              cnt_en,
    output logic [PAGE_W-1:0] cnt_page,
    input  logic [31:0]       cnt_rdata,
    output logic [15:0]       target_addr
);
    logic       req_acc;
    byte_kind_e req_kind;
    logic [1:0] req_idx;
    logic       req_cnt;
    logic       hdr_fold;

    pgrd_ctrl #(
        .PAGE_BYTES     (PAGE_BYTES),
        .PAGES          (PAGES),
        .CNT_FIRST_PAGE (CNT_FIRST_PAGE)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_rst     (bus_rst),
        .wr_valid    (wr_valid),
        .wr_data     (wr_data),
        .rd_req      (rd_req),
        .req_acc     (req_acc),
        .req_kind    (req_kind),
        .req_idx     (req_idx),
        .req_cnt     (req_cnt),
        .hdr_fold    (hdr_fold),
        .mem_en      (mem_en),
        .mem_addr    (mem_addr),
        .cnt_en      (cnt_en),
        .cnt_page    (cnt_page),
        .target_addr (target_addr)
    );

    pgrd_outstage #(.TAMPER(TAMPER)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_rst   (bus_rst),
        .req_acc   (req_acc),
        .req_kind  (req_kind),
        .req_idx   (req_idx),
        .req_cnt   (req_cnt),
        .hdr_fold  (hdr_fold),
        .wr_data   (wr_data),
        .mem_rdata (mem_rdata),
        .cnt_rdata (cnt_rdata),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    p_valid_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_req));
endmodule

// File: tb/paged_read_seq_tb.sv
module paged_read_seq_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rst = 1'b0;
    logic        wr_valid = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        rd_req = 1'b0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic        mem_en;
    logic [8:0]  mem_addr;
    logic [7:0]  mem_rdata = 8'h00;
    logic        cnt_en;
    logic [3:0]  cnt_page;
    logic [31:0] cnt_rdata = 32'h0;
    logic [15:0] target_addr;

    int checks = 0;
    int fails  = 0;

    always #(CLK_P/2) clk = ~clk;

    paged_read_seq u_dut (
        .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst),
        .wr_valid(wr_valid), .wr_data(wr_data),
        .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_en(mem_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .cnt_en(cnt_en), .cnt_page(cnt_page), .cnt_rdata(cnt_rdata),
        .target_addr(target_addr)
    );

    function automatic logic [7:0] mem_model(input int a);
        return 8'((a * 13 + 5) ^ (a >> 8));
    endfunction

    function automatic logic [31:0] cnt_model(input int p);
        return {8'hC0, 8'(p), 8'h5A ^ 8'(p), 8'h3E};
    endfunction

    function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ 16'hA001;
            else             r = r >> 1;
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (mem_en) mem_rdata <= mem_model(int'(mem_addr));
        if (cnt_en) cnt_rdata <= cnt_model(int'(cnt_page));
    end

    logic [7:0] exp_buf [0:1023];
    string      exp_tag [0:1023];

    task automatic gen_exp(input logic [7:0] cmd, input logic [15:0] ta, input int n);
        logic [15:0] c;
        int a;
        int k;
        int pg;
        logic [7:0] b;
        for (int i = 0; i < 1024; i++) begin
            exp_buf[i] = 8'hFF;
            exp_tag[i] = (cmd == 8'hF0) ? "R2" : ((cmd == 8'hA5) ? "R8" : "R10");
        end
        if (cmd == 8'hF0) begin
            a = int'(ta);
            for (int i = 0; i < n; i++) begin
                if (a < 512) begin
                    exp_buf[i] = mem_model(a);
                    exp_tag[i] = "R1";
                    a++;
                end
            end
        end else if (cmd == 8'hA5 && ta < 16'd512) begin
            c = crc_upd(16'h0, cmd);
            c = crc_upd(c, ta[7:0]);
            c = crc_upd(c, ta[15:8]);
            a = int'(ta);
            k = 0;
            while (k < n) begin
                exp_buf[k] = mem_model(a);
                exp_tag[k] = "R4";
                c = crc_upd(c, exp_buf[k]);
                k++;
                if (a % 32 == 31) begin
                    pg = a / 32;
                    for (int j = 0; j < 4; j++) begin
                        b = (pg >= 8) ? cnt_model(pg)[8*j +: 8] : 8'hFF;
                        exp_buf[k] = b; exp_tag[k] = "R5";
                        c = crc_upd(c, b); k++;
                    end
                    for (int j = 0; j < 4; j++) begin
                        exp_buf[k] = 8'h55; exp_tag[k] = "R4";
                        c = crc_upd(c, 8'h55); k++;
                    end
                    exp_buf[k] = ~c[7:0];  exp_tag[k] = (pg == int'(ta) / 32) ? "R6" : "R7"; k++;
                    exp_buf[k] = ~c[15:8]; exp_tag[k] = (pg == int'(ta) / 32) ? "R6" : "R7"; k++;
                    c = 16'h0;
                    if (pg == 15) break;
                end
                a++;
            end
        end
    endtask

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [7:0] d);
        @(negedge clk); wr_valid = 1'b1; wr_data = d;
        @(negedge clk); wr_valid = 1'b0;
    endtask

    task automatic rd_byte(output logic [7:0] d, output logic v);
        @(negedge clk); rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0;
        d = rd_data; v = rd_valid;
    endtask

    task automatic pulse_bus_rst();
        @(negedge clk); bus_rst = 1'b1;
        @(negedge clk); bus_rst = 1'b0;
    endtask

    task automatic start(input logic [7:0] cmd, input logic [15:0] a);
        pulse_bus_rst();
        wr_byte(cmd);
        wr_byte(a[7:0]);
        wr_byte(a[15:8]);
    endtask

    task automatic run_stream(input logic [7:0] cmd, input logic [15:0] a, input int n);
        logic [7:0] d;
        logic v;
        gen_exp(cmd, a, n);
        for (int i = 0; i < n; i++) begin
            rd_byte(d, v);
            chk(v, "R11", 32'(v), 32'd1);
            chk(d == exp_buf[i], exp_tag[i], 32'(d), 32'(exp_buf[i]));
        end
    endtask

    // {command, target address, read count}
    localparam logic [31:0] VECS [0:7] = '{
        {8'hF0, 16'h0000, 8'd20},
        {8'hF0, 16'h01FA, 8'd10},
        {8'hA5, 16'h0000, 8'd45},
        {8'hA5, 16'h011C, 8'd50},
        {8'hA5, 16'h01F8, 8'd30},
        {8'hA5, 16'h0205, 8'd5},
        {8'hF0, 16'h0300, 8'd4},
        {8'hA5, 16'h00E0, 8'd48}
    };

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R9, R3)
        chk(rd_valid == 1'b0, "R9", 32'(rd_valid), 32'd0);
        chk(target_addr == 16'h0, "R3", 32'(target_addr), 32'd0);
        // Read before any command returns ones (R11)
        rd_byte(d, v);
        chk(d == 8'hFF, "R11", 32'(d), 32'hFF);
        @(negedge clk);
        chk(rd_valid == 1'b0, "R11", 32'(rd_valid), 32'd0);

        // Vector table walk (R1, R2, R4, R5, R6, R7, R8)
        for (int i = 0; i < 8; i++) begin
            start(VECS[i][31:24], VECS[i][23:8]);
            chk(target_addr == VECS[i][23:8], "R3", 32'(target_addr), 32'(VECS[i][23:8]));
            run_stream(VECS[i][31:24], VECS[i][23:8], int'(VECS[i][7:0]));
        end

        // R9: bus reset mid-trailer-stream, then linear read works
        start(8'hA5, 16'h0110);
        run_stream(8'hA5, 16'h0110, 5);
        start(8'hF0, 16'h0040);
        gen_exp(8'hF0, 16'h0040, 3);
        for (int i = 0; i < 3; i++) begin
            rd_byte(d, v);
            chk(d == exp_buf[i], "R9", 32'(d), 32'(exp_buf[i]));
        end

        // R10: unknown command, later bytes ignored
        pulse_bus_rst();
        wr_byte(8'h3C);
        wr_byte(8'hF0);
        wr_byte(8'h12);
        wr_byte(8'h00);
        chk(target_addr == 16'h0040, "R10", 32'(target_addr), 32'h0040);
        rd_byte(d, v);
        chk(d == 8'hFF, "R10", 32'(d), 32'hFF);
        rd_byte(d, v);
        chk(d == 8'hFF, "R10", 32'(d), 32'hFF);

        // R11: read during address phase returns ones, then data
        pulse_bus_rst();
        wr_byte(8'hF0);
        wr_byte(8'h33);
        rd_byte(d, v);
        chk(d == 8'hFF, "R11", 32'(d), 32'hFF);
        wr_byte(8'h00);
        chk(target_addr == 16'h0033, "R3", 32'(target_addr), 32'h0033);
        rd_byte(d, v);
        chk(d == mem_model(16'h33), "R11", 32'(d), 32'(mem_model(16'h33)));

        // R11: write during data phase ignored
        wr_byte(8'h99);
        chk(target_addr == 16'h0033, "R11", 32'(target_addr), 32'h0033);
        rd_byte(d, v);
        chk(d == mem_model(16'h34), "R11", 32'(d), 32'(mem_model(16'h34)));

        // R6: first-page CRC with non-zero address low byte, page 9 counter
        start(8'hA5, 16'h013E);
        run_stream(8'hA5, 16'h013E, 12);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule